// File: doc/BRIEF.md
# Sliding-Window Convolution Data Loader

This block walks a k×k window across an N×N source matrix held in word-addressed memory and hands each window position to a downstream compute unit. It reads the source one column at a time: each group of k reads covers k vertically adjacent words of the current band of k rows. The words go into a circular store of k×k entries. When a band starts, k columns fill the store. After that, every horizontal step fetches a single fresh column, which overwrites the oldest one, so a step costs k reads instead of k×k.

The store's start pointer moves forward one column after each refill. The window on the output is therefore always ordered oldest column first, and the compute side never sees the rotation. After the last position of a band, the band moves down one row, the pointers clear, and a fresh fill begins. N and k are sampled from configuration inputs when `start` is accepted. `done` pulses once when the run ends. A fetch counter reports the number of reads issued in the current run. Memory reads return data one cycle after the request.

Top module: `cwl_loader`

## Requirements
- R1: After reset, `win_valid`, `busy`, `done`, `cfg_err` and `mem_rd_en` are low and `fetch_count` is zero.
- R2: Reads follow column-priority order. For band b (top row b, starting at 0) and column x, the k reads go to word addresses (b+r)·N+x for r = 0..k−1. Columns go in the order x = 0..N−1, and bands go in the order b = 0..N−k.
- R3: The first window of each band holds the source element at row b+r, column c in output slot (c, r), for c, r < k.
- R4: The window at horizontal offset x of band b holds element (b+r, x+c) in slot (c, r), with column c = 0 the oldest. Slot (c, r) is bits [(c·KMAX+r)·DW +: DW] of `win_data`. Slots with c ≥ k or r ≥ k read zero.
- R5: At the end of a valid run, `fetch_count` equals N·k·(N−k+1). For N = 5 and k = 3 this is 45.
- R6: A run delivers exactly (N−k+1)² windows in raster order, which is k·k·(N−k+1)² elements (81 for N = 5, k = 3).
- R7: While `win_valid` is high and `win_ready` is low, `win_data` and `win_valid` hold steady. No memory read is issued while a window is presented.
- R8: If k = 0, k > N or k > KMAX when `start` is accepted, `cfg_err` rises and `done` pulses the next cycle. No read is issued and no window is produced. `cfg_err` stays high until the next accepted start.
- R9: `done` is a single-cycle pulse, coincident with `busy` falling, after the last window is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run; accepted only while idle |
| cfg_n | input | NW | Source matrix side N |
| cfg_k | input | KW | Window side k |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| cfg_err | output | 1 | Last accepted start had an illegal k |
| mem_rd_en | output | 1 | Memory read request |
| mem_addr | output | AW | Word address of the read |
| mem_rd_data | input | DW | Read data, valid one cycle after the request |
| win_valid | output | 1 | Window available |
| win_ready | input | 1 | Downstream accepts the window |
| win_data | output | KMAX·KMAX·DW | Window, column-major, oldest column first |
| fetch_count | output | CW | Reads issued in the current run |

## Verification
The assertions take for granted that `cfg_n` and `cfg_k` stay constant from an accepted `start` until `done`. They also assume that memory answers every request with exactly one cycle of latency. The address-range property depends on both. The bench changes configuration only between runs, while the block is idle. Its memory model registers `address + 1` on every request, so each window element identifies the word it came from. The bench toggles `win_ready` in a repeating pattern, so stalls fall at many different window positions.

// File: rtl/cwl_pkg.sv
package cwl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_DRAIN,
    ST_EMIT,
    ST_HOLD
  } cwl_state_e;
endpackage

// File: rtl/cwl_seq.sv
module cwl_seq
  import cwl_pkg::*;
#(
  parameter int NW   = 8,
  parameter int KW   = 6,
  parameter int AW   = 16,
  parameter int KMAX = 32,
  localparam int SW  = (KMAX > 1) ? $clog2(KMAX) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [NW-1:0] cfg_n,
  input  logic [KW-1:0] cfg_k,
  input  logic          win_ready,
  output logic          busy,
  output logic          done,
  output logic          cfg_err,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic [SW-1:0] rd_row,
  output logic          rd_last,
  output logic          band_clr,
  output logic          emit,
  output logic          win_valid,
  output logic [KW-1:0] k_q
);
  cwl_state_e    state;
  logic [NW-1:0] n_q, row0, col;
  logic [KW-1:0] r;
  logic          bad;
  logic [NW:0]   row_end;
  logic [NW-1:0] k_m1;

  assign bad     = (cfg_k == '0) || (int'(cfg_k) > int'(cfg_n)) || (int'(cfg_k) > KMAX);
  assign row_end = {1'b0, row0} + (NW+1)'(k_q);
  assign k_m1    = NW'(k_q) - NW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      done     <= 1'b0;
      cfg_err  <= 1'b0;
      band_clr <= 1'b0;
      n_q      <= '0;
      k_q      <= '0;
      row0     <= '0;
      col      <= '0;
      r        <= '0;
    end else begin
      done     <= 1'b0;
      band_clr <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            n_q  <= cfg_n;
            k_q  <= cfg_k;
            row0 <= '0;
            col  <= '0;
            r    <= '0;
            if (bad) begin
              cfg_err <= 1'b1;
              done    <= 1'b1;
            end else begin
              cfg_err  <= 1'b0;
              band_clr <= 1'b1;
              state    <= ST_FETCH;
            end
          end
        end
        ST_FETCH: begin
          if (r == k_q - KW'(1)) begin
            r <= '0;
            if (col < k_m1) col <= col + NW'(1);
            else            state <= ST_DRAIN;
          end else begin
            r <= r + KW'(1);
          end
        end
        ST_DRAIN: state <= ST_EMIT;
        ST_EMIT:  state <= ST_HOLD;
        ST_HOLD: begin
          if (win_ready) begin
            if (col == n_q - NW'(1)) begin
              if (row_end == {1'b0, n_q}) begin
                done  <= 1'b1;
                state <= ST_IDLE;
              end else begin
                row0     <= row0 + NW'(1);
                col      <= '0;
                band_clr <= 1'b1;
                state    <= ST_FETCH;
              end
            end else begin
              col   <= col + NW'(1);
              state <= ST_FETCH;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state != ST_IDLE);
  assign rd_en     = (state == ST_FETCH);
  assign emit      = (state == ST_EMIT);
  assign win_valid = (state == ST_HOLD);
  assign rd_row    = SW'(r);
  assign rd_last   = (r == k_q - KW'(1));
  assign rd_addr   = AW'((32'(row0) + 32'(r)) * 32'(n_q) + 32'(col));
endmodule

// File: rtl/cwl_queue.sv
module cwl_queue #(
  parameter int DW   = 16,
  parameter int KW   = 6,
  parameter int KMAX = 32,
  localparam int SW  = (KMAX > 1) ? $clog2(KMAX) : 1,
  localparam int OW  = KMAX * KMAX * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [KW-1:0] k_q,
  input  logic          band_clr,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_row,
  input  logic          wr_last,
  input  logic [DW-1:0] wr_data,
  input  logic          emit,
  output logic [OW-1:0] win_data
);
  logic [DW-1:0] store [KMAX][KMAX];
  logic [DW-1:0] wq    [KMAX][KMAX];
  logic [SW-1:0] head, fill, wslot;
  logic          full;

  assign wslot = full ? head : fill;

  // column slot pointers: fill during the first k columns, then rotate
  always_ff @(posedge clk) begin
    if (rst || band_clr) begin
      head <= '0;
      fill <= '0;
      full <= 1'b0;
    end else if (wr_en && wr_last) begin
      if (!full) begin
        if (int'(fill) == int'(k_q) - 1) full <= 1'b1;
        else                             fill <= fill + SW'(1);
      end else begin
        head <= (int'(head) == int'(k_q) - 1) ? '0 : head + SW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) store[wslot][wr_row] <= wr_data;
  end

  for (genvar c = 0; c < KMAX; c++) begin : g_col
    logic [SW-1:0] slot;
    always_comb begin
      int s;
      s = int'(head) + c;
      if (s >= int'(k_q)) s = s - int'(k_q);
      slot = SW'(s);
    end
    for (genvar r = 0; r < KMAX; r++) begin : g_row
      always_ff @(posedge clk) begin
        if (rst)
          wq[c][r] <= '0;
        else if (emit)
          wq[c][r] <= (int'(k_q) > c && int'(k_q) > r) ? store[slot][r] : '0;
      end
      assign win_data[(c*KMAX+r)*DW +: DW] = wq[c][r];
    end
  end
endmodule

// File: rtl/cwl_loader.sv
module cwl_loader #(
  parameter int DW   = 16,
  parameter int AW   = 16,
  parameter int NW   = 8,
  parameter int KW   = 6,
  parameter int KMAX = 32,
  parameter int CW   = 32,
  localparam int SW  = (KMAX > 1) ? $clog2(KMAX) : 1,
  localparam int OW  = KMAX * KMAX * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [NW-1:0] cfg_n,
  input  logic [KW-1:0] cfg_k,
  output logic          busy,
  output logic          done,
  output logic          cfg_err,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rd_data,
  output logic          win_valid,
  input  logic          win_ready,
  output logic [OW-1:0] win_data,
  output logic [CW-1:0] fetch_count
);
  logic          rd_en, rd_last, band_clr, emit;
  logic [SW-1:0] rd_row;
  logic [KW-1:0] k_q;
  logic          rd_pend, rd_last_q;
  logic [SW-1:0] rd_row_q;

  cwl_seq #(.NW(NW), .KW(KW), .AW(AW), .KMAX(KMAX)) u_seq (
    .clk(clk), .rst(rst), .start(start), .cfg_n(cfg_n), .cfg_k(cfg_k),
    .win_ready(win_ready), .busy(busy), .done(done), .cfg_err(cfg_err),
    .rd_en(rd_en), .rd_addr(mem_addr), .rd_row(rd_row), .rd_last(rd_last),
    .band_clr(band_clr), .emit(emit), .win_valid(win_valid), .k_q(k_q)
  );

  // track the one-cycle read latency
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend   <= 1'b0;
      rd_row_q  <= '0;
      rd_last_q <= 1'b0;
    end else begin
      rd_pend   <= rd_en;
      rd_row_q  <= rd_row;
      rd_last_q <= rd_last;
    end
  end

  cwl_queue #(.DW(DW), .KW(KW), .KMAX(KMAX)) u_queue (
    .clk(clk), .rst(rst), .k_q(k_q), .band_clr(band_clr),
    .wr_en(rd_pend), .wr_row(rd_row_q), .wr_last(rd_last_q),
    .wr_data(mem_rd_data), .emit(emit), .win_data(win_data)
  );

  always_ff @(posedge clk) begin
    if (rst)                 fetch_count <= '0;
    else if (start && !busy) fetch_count <= '0;
    else if (rd_en)          fetch_count <= fetch_count + CW'(1);
  end

  assign mem_rd_en = rd_en;
endmodule

// File: rtl/cwl_loader_chk.sv
module cwl_loader_chk #(
  parameter int DW   = 16,
  parameter int AW   = 16,
  parameter int NW   = 8,
  parameter int KMAX = 32,
  parameter int CW   = 32,
  localparam int OW  = KMAX * KMAX * DW
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [NW-1:0] cfg_n,
  input logic          busy,
  input logic          done,
  input logic          cfg_err,
  input logic          mem_rd_en,
  input logic [AW-1:0] mem_addr,
  input logic          win_valid,
  input logic          win_ready,
  input logic [OW-1:0] win_data,
  input logic [CW-1:0] fetch_count
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!win_valid && !busy && !done && !cfg_err && !mem_rd_en && fetch_count == '0));

  p_addr_range_r2: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> (int'(mem_addr) < int'(cfg_n) * int'(cfg_n)));

  p_count_step_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en && !(start && !busy)) |=> fetch_count == $past(fetch_count) + CW'(1));

  p_hold_stable_r7: assert property (@(posedge clk) disable iff (rst)
    (win_valid && !win_ready) |=> (win_valid && $stable(win_data)));

  p_no_fetch_while_valid_r7: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> !mem_rd_en);

  p_err_silent_r8: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> (!win_valid && !mem_rd_en));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

bind cwl_loader cwl_loader_chk #(
  .DW(DW), .AW(AW), .NW(NW), .KMAX(KMAX), .CW(CW)
) u_chk (.*);

// File: tb/test_cwl_loader.sv
module test_cwl_loader;
  localparam int CLK_PERIOD = 10;
  localparam int DW   = 16;
  localparam int AW   = 16;
  localparam int NW   = 8;
  localparam int KW   = 6;
  localparam int KMAX = 4;
  localparam int CW   = 32;
  localparam int OW   = KMAX * KMAX * DW;

  logic          clk = 1'b0;
  logic          rst, start, win_ready;
  logic [NW-1:0] cfg_n;
  logic [KW-1:0] cfg_k;
  logic          busy, done, cfg_err, mem_rd_en, win_valid;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rd_data;
  logic [OW-1:0] win_data;
  logic [CW-1:0] fetch_count;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // memory model: word at address a holds a+1, one-cycle latency
  always_ff @(posedge clk) begin
    if (mem_rd_en) mem_rd_data <= DW'(32'(mem_addr) + 1);
  end

  cwl_loader #(.DW(DW), .AW(AW), .NW(NW), .KW(KW), .KMAX(KMAX), .CW(CW)) i_cwl_loader (
    .clk(clk), .rst(rst), .start(start), .cfg_n(cfg_n), .cfg_k(cfg_k),
    .busy(busy), .done(done), .cfg_err(cfg_err), .mem_rd_en(mem_rd_en),
    .mem_addr(mem_addr), .mem_rd_data(mem_rd_data), .win_valid(win_valid),
    .win_ready(win_ready), .win_data(win_data), .fetch_count(fetch_count)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_window(input int n, input int k, input int b, input int x);
    int bad_cnt = 0;
    int a_first = 0;
    int e_first = 0;
    for (int c = 0; c < KMAX; c++) begin
      for (int r = 0; r < KMAX; r++) begin
        int e;
        int a;
        e = (c < k && r < k) ? (b + r) * n + x + c + 1 : 0;
        a = int'(win_data[(c*KMAX+r)*DW +: DW]);
        if (a != e) begin
          if (bad_cnt == 0) begin a_first = a; e_first = e; end
          bad_cnt++;
        end
      end
    end
    if (x == 0) chk(bad_cnt == 0, "R3 first window of band", a_first, e_first);
    else        chk(bad_cnt == 0, "R4 window content/order", a_first, e_first);
  endtask

  task automatic run_cfg(input int n, input int k);
    bit   bad_cfg;
    int   rb = 0, rx = 0, rr = 0;
    int   wb = 0, wx = 0, nwin = 0;
    int   cyc = 0, rd_total = 0, overlap = 0;
    bit   seen_done = 1'b0;
    bit   held = 1'b0;
    logic [OW-1:0] held_data = '0;
    bad_cfg = (k == 0) || (k > n) || (k > KMAX);
    @(negedge clk);
    cfg_n = NW'(n);
    cfg_k = KW'(k);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!seen_done && cyc < 20000) begin
      if (done) seen_done = 1'b1;
      if (mem_rd_en) begin
        int ea;
        ea = (rb + rr) * n + rx;
        rd_total++;
        chk(int'(mem_addr) == ea, "R2 read address order", int'(mem_addr), ea);
        rr++;
        if (rr == k) begin
          rr = 0; rx++;
          if (rx == n) begin rx = 0; rb++; end
        end
      end
      if (win_valid && mem_rd_en) overlap++;
      if (held) begin
        chk(win_valid && win_data == held_data, "R7 window held during stall",
            int'(win_valid), 1);
        held = 1'b0;
      end
      win_ready = ((cyc % 3) != 1);
      if (win_valid) begin
        if (win_ready) begin
          check_window(n, k, wb, wx);
          nwin++;
          wx++;
          if (wx > n - k) begin wx = 0; wb++; end
        end else begin
          held = 1'b1;
          held_data = win_data;
        end
      end
      cyc++;
      if (!seen_done) @(negedge clk);
    end
    win_ready = 1'b0;
    chk(seen_done, "R9 done reached (watchdog)", int'(seen_done), 1);
    @(negedge clk);
    chk(!done && !busy, "R9 done single pulse, idle after", int'(done) + int'(busy), 0);
    if (bad_cfg) begin
      chk(cfg_err == 1'b1, "R8 cfg_err on illegal k", int'(cfg_err), 1);
      chk(nwin == 0 && rd_total == 0 && fetch_count == '0,
          "R8 no reads or windows on illegal k", nwin + rd_total, 0);
    end else begin
      chk(cfg_err == 1'b0, "R8 cfg_err low on legal k", int'(cfg_err), 0);
      chk(int'(fetch_count) == n * k * (n - k + 1), "R5 fetch total",
          int'(fetch_count), n * k * (n - k + 1));
      chk(rd_total == n * k * (n - k + 1), "R5 observed reads",
          rd_total, n * k * (n - k + 1));
      chk(nwin == (n - k + 1) * (n - k + 1), "R6 window count",
          nwin, (n - k + 1) * (n - k + 1));
      chk(overlap == 0, "R7 no read while window presented", overlap, 0);
    end
  endtask

  initial begin
    rst = 1'b1; start = 1'b0; win_ready = 1'b0; cfg_n = '0; cfg_k = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!win_valid && !busy && !done && !cfg_err && !mem_rd_en, "R1 reset outputs low",
        int'(win_valid) + int'(busy) + int'(done) + int'(cfg_err) + int'(mem_rd_en), 0);
    chk(fetch_count == '0, "R1 fetch_count zero", int'(fetch_count), 0);

    // 5x5 source, 3x3 window: 45 reads, 9 windows of 9 elements
    run_cfg(5, 3);
    chk(int'(fetch_count) == 45, "R5 5x5/3x3 fetch total", int'(fetch_count), 45);

    for (int n = 1; n <= 8; n++) begin
      for (int k = 0; k <= KMAX + 1; k++) begin
        run_cfg(n, k);
      end
    end

    // R6: consumed element total for the 5x5/3x3 case
    begin
      int wins = 0;
      int cyc  = 0;
      @(negedge clk);
      cfg_n = NW'(5); cfg_k = KW'(3); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      win_ready = 1'b1;
      while (!done && cyc < 20000) begin
        if (win_valid) wins++;
        cyc++;
        @(negedge clk);
      end
      win_ready = 1'b0;
      chk(3 * 3 * wins == 81, "R6 5x5/3x3 elements consumed", 3 * 3 * wins, 81);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule